// File: doc/BRIEF.md
# DMA Audio Frame Address Controller

This block walks a memory address range for audio playback. Software loads a start word address and a stop word address, then sets a run bit in the control register. From then on the block keeps a current word address. It asks the bus arbiter for a word whenever the downstream sample FIFO has room. Each granted fetch moves the address on by one word. The word that memory returns is passed into the FIFO.

The stop address is copied into a shadow register when a frame begins, so software may rewrite it for the next frame while the current frame runs. When the loop bit is set, the frame restarts from whatever start address is in the register at that moment. An active-low activity line is low while a frame is being fetched. It goes high as soon as the fetch address meets the shadowed stop address. In loop mode it stays high for a short, fixed number of clocks at each restart, which gives software one clean edge per frame.

Top module: `dma_frame_sequencer`

## Requirements
- R1: After reset the block is idle: `act_n` is 1, `fetch_req` is 0, and every register reads 0.
- R2: A control write (offset 0) with bit 0 set while idle loads the current address from the start register and shadows the stop register. From the next cycle `act_n` is 0 and `fetch_addr` shows the start address.
- R3: `fetch_req` is high only while a frame is being fetched, the current address differs from the shadowed stop address, and `fifo_full` is 0. Each cycle with `bus_grant` and `fetch_req` both high advances the current address by exactly one.
- R4: The word on `mem_rdata` in the cycle after a grant appears on `fifo_wdata`, with `fifo_push` high, two cycles after the grant.
- R5: Writes to the stop register (offset 2) while a frame runs do not change the number of words that frame fetches.
- R6: Without the loop bit, once the current address equals the shadowed stop address, fetching ends, `act_n` returns to 1 and control bit 0 reads 0.
- R7: With the loop bit (control bit 1) set, reaching the stop address raises `act_n` for exactly PULSE_CYC cycles. The current address is reloaded from the start register as it stands at that moment, the stop address is shadowed again, and then `act_n` falls and fetching resumes.
- R8: A control write with bit 0 clear during playback drops `fetch_req` and raises `act_n` from the next cycle, and control bit 0 then reads 0.
- R9: A control write with bit 0 set while playing does not restart the frame: the current address keeps its value.
- R10: A frame whose start address equals its stop address completes without any fetch.
- R11: Register reads return data one cycle after `reg_addr` is presented. Offset 0 returns the live run state in bit 0 and the loop bit in bit 1. Offsets 1 and 2 return the start and stop values last written. Offset 3 returns the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for writes and reads |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data |
| fifo_full | input | 1 | Downstream sample FIFO has no room |
| fetch_req | output | 1 | Word fetch request to the bus arbiter |
| fetch_addr | output | ADDR_W | Word address of the requested fetch |
| bus_grant | input | 1 | Arbiter grant strobe for the current request |
| mem_rdata | input | DATA_W | Memory data, valid the cycle after a grant |
| fifo_push | output | 1 | Write strobe into the sample FIFO |
| fifo_wdata | output | DATA_W | Sample word for the FIFO |
| act_n | output | 1 | Active-low frame activity line |

## Verification
The bench rewrites the stop address in the middle of a frame. A design that used the live register would end that frame early and fetch too few words. In loop mode it moves the start register before the restart and times the high pulse on `act_n`. A restart from a stale start value, or a pulse one clock off, shows up as a wrong first address or a wrong length. It also writes the run bit again during playback, which would rewind the address in a design that treated that write as a new start. A zero-length frame must fetch nothing, where an off-by-one compare would fetch one word.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_STOP = 2'd2;
  localparam logic [1:0] RA_CUR  = 2'd3;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_LOOP_BIT = 1;
endpackage

// File: rtl/dfs_regs.sv
module dfs_regs
  import dfs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              running,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] stop_q,
  output logic              loop_q,
  output logic              start_req,
  output logic              stop_req,
  output logic [ADDR_W-1:0] reg_rdata
);
  logic ctrl_wr;
  logic [ADDR_W-1:0] rd_mux;

  assign ctrl_wr   = reg_we && (reg_addr == RA_CTRL);
  assign start_req = ctrl_wr && reg_wdata[CTRL_RUN_BIT];
  assign stop_req  = ctrl_wr && !reg_wdata[CTRL_RUN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      stop_q <= '0;
      loop_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: loop_q <= reg_wdata[CTRL_LOOP_BIT];
        RA_BASE: base_q <= reg_wdata;
        RA_STOP: stop_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL: begin
        rd_mux[CTRL_RUN_BIT]  = running;
        rd_mux[CTRL_LOOP_BIT] = loop_q;
      end
      RA_BASE: rd_mux = base_q;
      RA_STOP: rd_mux = stop_q;
      default: rd_mux = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  AST_STOP_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_STOP) |=> (stop_q == $past(reg_wdata))); // R11
endmodule

// File: rtl/dfs_frame_ctrl.sv
module dfs_frame_ctrl
  import dfs_pkg::*;
#(
  parameter int PULSE_CYC = 1688
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic loop_q,
  input  logic at_end,
  output logic load,
  output logic fetch_en,
  output logic running,
  output logic act_n
);
  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(PULSE_CYC - 1);

  seq_state_t state_q;
  logic [CNT_W-1:0] gap_cnt_q;
  logic wrap;

  assign wrap     = (state_q == ST_RUN) && !stop_req && at_end && loop_q;
  assign load     = ((state_q == ST_IDLE) && start_req) || wrap;
  assign fetch_en = (state_q == ST_RUN);
  assign running  = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      act_n     <= 1'b1;
      gap_cnt_q <= '0;
    end else if (stop_req && state_q != ST_IDLE) begin
      state_q <= ST_IDLE;
      act_n   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start_req) begin
          state_q <= ST_RUN;
          act_n   <= 1'b0;
        end
        ST_RUN: if (at_end) begin
          act_n <= 1'b1;
          if (loop_q) begin
            state_q   <= ST_GAP;
            gap_cnt_q <= GAP_LAST;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (gap_cnt_q == '0) begin
            state_q <= ST_RUN;
            act_n   <= 1'b0;
          end else begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          act_n   <= 1'b1;
        end
      endcase
    end
  end

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> act_n); // R1
  AST_GAP_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> act_n); // R7
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (stop_req && state_q != ST_IDLE) |=> (state_q == ST_IDLE && act_n)); // R8
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_req && state_q == ST_RUN && !at_end) |=> (state_q == ST_RUN && !act_n)); // R9
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && at_end && !loop_q) |=> (state_q == ST_IDLE)); // R6
endmodule

// File: rtl/dfs_addr_gen.sv
module dfs_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] stop_q,
  input  logic              fetch_en,
  input  logic              fifo_full,
  input  logic              bus_grant,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] cur_q,
  output logic              at_end,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wdata
);
  logic [ADDR_W-1:0] stop_lat_q;
  logic granted;
  logic pend_q;

  assign at_end    = (cur_q == stop_lat_q);
  assign fetch_req = fetch_en && !at_end && !fifo_full;
  assign granted   = bus_grant && fetch_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      stop_lat_q <= '0;
    end else if (load) begin
      cur_q      <= base_q;
      stop_lat_q <= stop_q;
    end else if (granted) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      pend_q    <= granted;
      fifo_push <= pend_q;
      if (pend_q) fifo_wdata <= mem_rdata;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (granted && !load) |=> (cur_q == $past(cur_q) + ADDR_W'(1))); // R3
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(stop_lat_q)); // R5
  AST_PUSH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    granted |-> ##2 fifo_push); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!granted && !load) |=> $stable(cur_q)); // R9
endmodule

// File: rtl/dma_frame_sequencer.sv
module dma_frame_sequencer #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PULSE_CYC = 1688
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              fifo_full,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              bus_grant,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              act_n
);
  logic [ADDR_W-1:0] base_q, stop_q, cur_q;
  logic loop_q, start_req, stop_req;
  logic load, fetch_en, running, at_end;

  dfs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .running(running), .cur_addr(cur_q),
    .base_q(base_q), .stop_q(stop_q), .loop_q(loop_q),
    .start_req(start_req), .stop_req(stop_req), .reg_rdata(reg_rdata)
  );

  dfs_frame_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .loop_q(loop_q), .at_end(at_end), .load(load), .fetch_en(fetch_en),
    .running(running), .act_n(act_n)
  );

  dfs_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .load(load), .base_q(base_q), .stop_q(stop_q),
    .fetch_en(fetch_en), .fifo_full(fifo_full), .bus_grant(bus_grant),
    .mem_rdata(mem_rdata), .fetch_req(fetch_req), .cur_q(cur_q),
    .at_end(at_end), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
  );

  assign fetch_addr = cur_q;

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fetch_req); // R3
  AST_REQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> !act_n); // R6
endmodule

// File: tb/tb_dma_frame_sequencer.sv
module tb_dma_frame_sequencer;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PULSE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic fifo_full = 1'b0;
  logic fetch_req;
  logic [AW-1:0] fetch_addr;
  logic bus_grant;
  logic gnt_en = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic fifo_push;
  logic [DW-1:0] fifo_wdata;
  logic act_n;

  int total = 0;
  int bad = 0;
  int gcount = 0;
  int pcount = 0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  assign bus_grant = gnt_en && fetch_req;

  dma_frame_sequencer #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_full(fifo_full),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .bus_grant(bus_grant),
    .mem_rdata(mem_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .act_n(act_n)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory stub and grant/push bookkeeping
  always @(posedge clk) begin
    if (bus_grant && fetch_req) begin
      gcount++;
      exp_q.push_back(word_of(fetch_addr));
      mem_rdata <= word_of(fetch_addr);
    end else begin
      mem_rdata <= 16'hDEAD;
    end
    if (fifo_push) begin
      pcount++;
      if (exp_q.size() == 0) chk(1'b0, "R4 push without grant", 32'(fifo_wdata), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(fifo_wdata == e, "R4 fifo word", 32'(fifo_wdata), 32'(e));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_act(input logic lvl, input string req);
    int n = 0;
    while (act_n !== lvl && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (n >= 500) chk(1'b0, req, 32'(act_n), 32'(lvl));
  endtask

  task automatic t_reset();
    logic [AW-1:0] d;
    chk(act_n == 1'b1, "R1 act_n", 32'(act_n), 1);
    chk(fetch_req == 1'b0, "R1 fetch_req", 32'(fetch_req), 0);
    rd(2'd0, d); chk(d == 0, "R1 ctrl", 32'(d), 0);
    rd(2'd3, d); chk(d == 0, "R1 cur", 32'(d), 0);
  endtask

  task automatic t_single();
    int g0;
    logic [AW-1:0] d;
    wr(2'd1, 20'h100); wr(2'd2, 20'h108);
    gnt_en = 1'b0;
    g0 = gcount;
    wr(2'd0, 20'h1);
    chk(act_n == 1'b0, "R2 act_n low", 32'(act_n), 0);
    chk(fetch_addr == 20'h100, "R2 start addr", 32'(fetch_addr), 32'h100);
    rd(2'd0, d); chk(d == 20'h1, "R11 ctrl running", 32'(d), 1);
    gnt_en = 1'b1;
    wait_act(1'b1, "R6 frame end timeout");
    chk(gcount - g0 == 8, "R6 word count", 32'(gcount - g0), 8);
    chk(fetch_req == 1'b0, "R6 no req after end", 32'(fetch_req), 0);
    rd(2'd0, d); chk(d == 0, "R6 ctrl bit0", 32'(d), 0);
    rd(2'd3, d); chk(d == 20'h108, "R11 cur at end", 32'(d), 32'h108);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fifo_full();
    logic [AW-1:0] d;
    int g0;
    gnt_en = 1'b1;
    fifo_full = 1'b1;
    wr(2'd1, 20'h180); wr(2'd2, 20'h184);
    g0 = gcount;
    wr(2'd0, 20'h1);
    repeat (4) @(negedge clk);
    chk(fetch_req == 1'b0, "R3 full blocks req", 32'(fetch_req), 0);
    rd(2'd3, d); chk(d == 20'h180, "R3 addr held while full", 32'(d), 32'h180);
    fifo_full = 1'b0;
    @(negedge clk);
    wait_act(1'b1, "R3 frame end timeout");
    chk(gcount - g0 == 4, "R3 grant count", 32'(gcount - g0), 4);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_end_latch();
    logic [AW-1:0] d;
    int g0;
    gnt_en = 1'b0;
    wr(2'd1, 20'h200); wr(2'd2, 20'h210);
    g0 = gcount;
    wr(2'd0, 20'h1);
    wr(2'd2, 20'h204);
    rd(2'd2, d); chk(d == 20'h204, "R11 stop readback", 32'(d), 32'h204);
    gnt_en = 1'b1;
    wait_act(1'b1, "R5 frame end timeout");
    chk(gcount - g0 == 16, "R5 shadowed stop", 32'(gcount - g0), 16);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_loop();
    logic [AW-1:0] d;
    int g0, hi;
    gnt_en = 1'b0;
    wr(2'd1, 20'h300); wr(2'd2, 20'h304);
    g0 = gcount;
    wr(2'd0, 20'h3);
    wr(2'd1, 20'h400); wr(2'd2, 20'h402);
    gnt_en = 1'b1;
    wait_act(1'b1, "R7 first wrap timeout");
    chk(gcount - g0 == 4, "R7 first frame words", 32'(gcount - g0), 4);
    hi = 0;
    while (act_n == 1'b1 && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == PULSE, "R7 pulse length", 32'(hi), PULSE);
    chk(fetch_addr == 20'h400, "R7 reload from live start", 32'(fetch_addr), 32'h400);
    g0 = gcount;
    wait_act(1'b1, "R7 second wrap timeout");
    chk(gcount - g0 == 2, "R7 second frame words", 32'(gcount - g0), 2);
    wait_act(1'b0, "R7 resume timeout");
    rd(2'd0, d); chk(d == 20'h3, "R11 ctrl loop+run", 32'(d), 3);
    wr(2'd0, 20'h0);
    chk(fetch_req == 1'b0, "R8 req dropped", 32'(fetch_req), 0);
    chk(act_n == 1'b1, "R8 act_n high", 32'(act_n), 1);
    rd(2'd0, d); chk(d == 0, "R8 ctrl bit0", 32'(d), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_restart();
    logic [AW-1:0] d;
    gnt_en = 1'b0;
    wr(2'd1, 20'h500); wr(2'd2, 20'h510);
    wr(2'd0, 20'h1);
    gnt_en = 1'b1;
    repeat (3) @(negedge clk);
    gnt_en = 1'b0;
    wr(2'd0, 20'h1);
    rd(2'd3, d); chk(d == 20'h503, "R9 no restart", 32'(d), 32'h503);
    chk(act_n == 1'b0, "R9 still active", 32'(act_n), 0);
    wr(2'd0, 20'h0);
    chk(act_n == 1'b1, "R8 stop mid frame", 32'(act_n), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_empty();
    logic [AW-1:0] d;
    int g0;
    gnt_en = 1'b1;
    wr(2'd1, 20'h600); wr(2'd2, 20'h600);
    g0 = gcount;
    wr(2'd0, 20'h1);
    repeat (5) @(negedge clk);
    chk(gcount == g0, "R10 no fetch", 32'(gcount - g0), 0);
    chk(act_n == 1'b1, "R10 act_n", 32'(act_n), 1);
    rd(2'd0, d); chk(d == 0, "R10 ctrl bit0", 32'(d), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_fifo_full();
    t_end_latch();
    t_loop();
    t_restart();
    t_empty();
    repeat (4) @(negedge clk);
    chk(pcount == gcount, "R4 push count", 32'(pcount), 32'(gcount));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule